// File: doc/BRIEF.md
# External bus chip-select and wait-state generator

This block sits between a processor's external bus request and the outside memory devices. For each request it decodes the 20-bit address into one of four active-low select lines. It then holds that line low for a number of wait cycles chosen per select, and it raises a one-cycle ready when the access is done. Each select owns a fixed 128 KB window in the upper half of the 1 MB space. Select 0 takes the highest window and select 3 the lowest of the four.

Two 8-bit registers set the behaviour, and software writes and reads them through a small register port. The control register holds one enable bit and one no-wait bit per select. The extension register holds a 2-bit code per select, and that code picks how many wait cycles an access takes while its no-wait bit is clear. A processor-mode input can switch every select off at once: in single-chip mode the pins are left as ordinary ports and accesses finish at once.

Top module: `ext_cs_wait`

## Requirements
- R1: After reset the control register reads 0x01, the extension register reads 0x00, all of `csN` are high and `busReady` is low.
- R2: Select i covers addresses from 0xE0000 − i·0x20000 to 0xFFFFF − i·0x20000, so select 0 takes 0xE0000–0xFFFFF and select 3 takes 0x80000–0x9FFFF. An address below 0x80000 drives no select.
- R3: Control register bit i (i = 0..3) enables select i. When that bit is clear, an access to window i drives no select line, takes zero wait cycles and reports `selDriven` low.
- R4: Control register bit 4+i set means select i takes zero wait cycles. When it is clear, extension bits [2i+1:2i] set the count: code 00 gives 1 wait cycle, 01 gives 2 and 10 gives 3.
- R5: A write to the extension register treats each field on its own. A field carrying code 11, or a nonzero code while that select's no-wait bit is set, is dropped and keeps its old value. The other fields of the same write still take effect.
- R6: A control register write that sets no-wait bit 4+i also clears extension field i to 00.
- R7: `procMode` 01 (memory expansion) and 10 (microprocessor) let the selects act. In modes 00 (single-chip) and 11 (treated as single-chip) no select is driven and every access takes zero wait cycles.
- R8: A request seen high in idle at a rising edge starts an access. The chosen `csN` line is low from the next cycle for W+1 cycles, where W is the wait count. `busReady` is high only in the last of those cycles. `selDriven` shows in that cycle whether a select line was driven.
- R9: At most one `csN` line is low at any time, and it does not change during an access.
- R10: `regRdData` shows the control register while `regSel` is 0 and the extension register while `regSel` is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procMode | input | 2 | Processor mode: 00 single-chip, 01 memory expansion, 10 microprocessor, 11 single-chip |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 extension |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Contents of the selected register |
| busReq | input | 1 | External access request, held until ready |
| busAddr | input | 20 | External access address |
| busReady | output | 1 | Access completes in this cycle |
| csN | output | 4 | Active-low chip-select lines |
| selDriven | output | 1 | A select line is driven for the current access |

## Verification
The bench builds the block with its defaults: four selects, 20 address bits and 17-bit windows. This puts all four windows in the upper half of the space and leaves a lower half that no window covers. The 2-bit wait counter can reach its largest count of three. Random register writes with random codes produce reserved codes, nonzero codes under a set no-wait bit, and no-wait bits that clear fields, so every write rule is exercised. Random modes, including the reserved one, are run against random addresses weighted toward the windows, so every select is met enabled, disabled and switched off by mode.

// File: rtl/ext_cs_pkg.sv
package ext_cs_pkg;

  localparam int EXT_FIELD_W = 2;
  localparam int WAIT_W      = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_MICRO  = 2'b10,
    MODE_RSVD   = 2'b11
  } proc_mode_e;

  typedef struct packed {
    logic capture;
    logic busy;
  } bus_strobe_t;

endpackage

// File: rtl/ext_cs_ctrl.sv
module ext_cs_ctrl
  import ext_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [WAIT_W-1:0] waitCount,
  output bus_strobe_t       strobe,
  output logic              busReady
);

  typedef enum logic {ST_IDLE, ST_ACCESS} state_e;

  state_e            state;
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (busReq) begin
            state <= ST_ACCESS;
            cnt   <= waitCount;
          end
        end
        ST_ACCESS: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - WAIT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (state == ST_IDLE) && busReq;
    strobe.busy    = (state == ST_ACCESS);
    busReady       = strobe.busy && (cnt == '0);
  end

endmodule

// File: rtl/ext_cs_datapath.sv
module ext_cs_datapath
  import ext_cs_pkg::*;
#(
  parameter  int NUM_CS   = 4,
  parameter  int ADDR_W   = 20,
  parameter  int WIN_BITS = 17,
  localparam int REG_W    = 2 * NUM_CS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        procMode,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [ADDR_W-1:0] busAddr,
  input  bus_strobe_t       strobe,
  output logic [WAIT_W-1:0] waitCount,
  output logic [NUM_CS-1:0] csN,
  output logic              selDriven,
  output logic [REG_W-1:0]  ctrlQ,
  output logic [REG_W-1:0]  expQ
);

  localparam int TOP_IDX = (1 << (ADDR_W - WIN_BITS)) - 1;
  localparam logic [REG_W-1:0] CTRL_RESET = REG_W'(1);

  logic [EXT_FIELD_W-1:0] expField [NUM_CS];
  logic [NUM_CS-1:0]      hitVec;
  logic [NUM_CS-1:0]      selQ;
  logic                   modeActive;

  assign modeActive = (procMode == MODE_EXPAND) || (procMode == MODE_MICRO);

  always_ff @(posedge clk) begin
    if (!rstN)                    ctrlQ <= CTRL_RESET;
    else if (regWrEn && !regSel)  ctrlQ <= regWrData;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'((TOP_IDX - i) << WIN_BITS);
    localparam logic [ADDR_W-1:0] WIN_HI = WIN_LO + ADDR_W'((1 << WIN_BITS) - 1);

    logic [EXT_FIELD_W-1:0] newField;
    logic                   fieldOk;

    assign newField = regWrData[EXT_FIELD_W*i +: EXT_FIELD_W];
    assign fieldOk  = (newField != '1) && !(ctrlQ[NUM_CS+i] && (newField != '0));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        expField[i] <= '0;
      end else if (regWrEn) begin
        if (!regSel) begin
          if (regWrData[NUM_CS+i]) expField[i] <= '0;
        end else if (fieldOk) begin
          expField[i] <= newField;
        end
      end
    end

    assign hitVec[i] = (busAddr >= WIN_LO) && (busAddr <= WIN_HI)
                       && ctrlQ[i] && modeActive;
  end

  always_comb begin
    expQ = '0;
    for (int i = 0; i < NUM_CS; i++) expQ[EXT_FIELD_W*i +: EXT_FIELD_W] = expField[i];
  end

  always_comb begin
    waitCount = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hitVec[i])
        waitCount = ctrlQ[NUM_CS+i] ? '0 : WAIT_W'(expField[i]) + WAIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               selQ <= '0;
    else if (strobe.capture) selQ <= hitVec;
  end

  assign csN       = ~(selQ & {NUM_CS{strobe.busy}});
  assign selDriven = strobe.busy && (|selQ);
  assign regRdData = regSel ? expQ : ctrlQ;

endmodule

// File: rtl/ext_cs_wait.sv
module ext_cs_wait
  import ext_cs_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int ADDR_W   = 20,
  parameter int WIN_BITS = 17
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            procMode,
  input  logic                  regWrEn,
  input  logic                  regSel,
  input  logic [2*NUM_CS-1:0]   regWrData,
  output logic [2*NUM_CS-1:0]   regRdData,
  input  logic                  busReq,
  input  logic [ADDR_W-1:0]     busAddr,
  output logic                  busReady,
  output logic [NUM_CS-1:0]     csN,
  output logic                  selDriven
);

  bus_strobe_t          strobe;
  logic [WAIT_W-1:0]    waitCount;
  logic [2*NUM_CS-1:0]  ctrlQ;
  logic [2*NUM_CS-1:0]  expQ;

  ext_cs_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busReq    (busReq),
    .waitCount (waitCount),
    .strobe    (strobe),
    .busReady  (busReady)
  );

  ext_cs_datapath #(
    .NUM_CS   (NUM_CS),
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .procMode  (procMode),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busAddr   (busAddr),
    .strobe    (strobe),
    .waitCount (waitCount),
    .csN       (csN),
    .selDriven (selDriven),
    .ctrlQ     (ctrlQ),
    .expQ      (expQ)
  );

endmodule

// File: rtl/ext_cs_wait_chk.sv
module ext_cs_wait_chk #(
  parameter int NUM_CS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                busReady,
  input logic [NUM_CS-1:0]   csN,
  input logic                selDriven,
  input logic [2*NUM_CS-1:0] ctrlQ,
  input logic [2*NUM_CS-1:0] expQ
);

  function automatic logic noReserved(input logic [2*NUM_CS-1:0] e);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_CS; i++) if (e[2*i +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic waitBitsClear(input logic [2*NUM_CS-1:0] c,
                                         input logic [2*NUM_CS-1:0] e);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_CS; i++) if (c[NUM_CS+i] && (e[2*i +: 2] != 2'b00)) ok = 1'b0;
    return ok;
  endfunction

  // R9: never two selects at once
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R9: select lines hold through an access
  a_r9_cs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && (csN != '1)) |=> $stable(csN));

  // R8: ready lasts a single cycle
  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  // R8: driven flag agrees with the select lines at completion
  a_r8_driven_matches: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> (selDriven == (csN != '1)));

  // R5: the reserved code never lands in a field
  a_r5_no_reserved_code: assert property (@(posedge clk) disable iff (!rstN)
    noReserved(expQ));

  // R6: a set no-wait bit always sees a zero field
  a_r6_wait_bit_clears_ext: assert property (@(posedge clk) disable iff (!rstN)
    waitBitsClear(ctrlQ, expQ));

endmodule

bind ext_cs_wait ext_cs_wait_chk #(.NUM_CS(NUM_CS)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busReady  (busReady),
  .csN       (csN),
  .selDriven (selDriven),
  .ctrlQ     (ctrlQ),
  .expQ      (expQ)
);

// File: tb/test_ext_cs_wait.sv
`timescale 1ns/1ps
module test_ext_cs_wait;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  procMode = 2'b01;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        busReq = 1'b0;
  logic [19:0] busAddr = '0;
  logic        busReady;
  logic [3:0]  csN;
  logic        selDriven;

  int checks = 0;
  int errors = 0;
  logic [7:0] mCtrl = 8'h01;
  logic [7:0] mExp  = 8'h00;

  always #5 clk = ~clk;

  ext_cs_wait i_ext_cs_wait (
    .clk(clk), .rstN(rstN), .procMode(procMode), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .busReq(busReq), .busAddr(busAddr), .busReady(busReady),
    .csN(csN), .selDriven(selDriven)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mdlSel(input logic [19:0] a, input logic [7:0] c,
                                        input logic [1:0] m);
    logic [3:0] s = '0;
    for (int i = 0; i < 4; i++)
      if ((a[19:17] == 3'(7 - i)) && c[i] && (m == 2'b01 || m == 2'b10)) s[i] = 1'b1;
    return s;
  endfunction

  function automatic int mdlWaits(input logic [3:0] s, input logic [7:0] c,
                                  input logic [7:0] e);
    int w = 0;
    for (int i = 0; i < 4; i++)
      if (s[i]) w = c[4+i] ? 0 : int'(e[2*i +: 2]) + 1;
    return w;
  endfunction

  task automatic regWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (!sel) begin
      mCtrl = d;
      for (int i = 0; i < 4; i++) if (d[4+i]) mExp[2*i +: 2] = 2'b00;
    end else begin
      for (int i = 0; i < 4; i++) begin
        logic [1:0] f = d[2*i +: 2];
        if (f != 2'b11 && !(mCtrl[4+i] && f != 2'b00)) mExp[2*i +: 2] = f;
      end
    end
  endtask

  task automatic readBack(input string tag);
    regSel = 1'b0; #1;
    check({tag, " R10 ctrl read"}, 32'(regRdData), 32'(mCtrl));
    regSel = 1'b1; #1;
    check({tag, " R10/R5/R6 ext read"}, 32'(regRdData), 32'(mExp));
  endtask

  task automatic access(input string tag, input logic [19:0] a);
    logic [3:0] s = mdlSel(a, mCtrl, procMode);
    int w = mdlWaits(s, mCtrl, mExp);
    int lat = 0;
    logic csOk = 1'b1;
    logic drv = 1'b0;
    @(negedge clk);
    busAddr = a; busReq = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (csN !== ~s) csOk = 1'b0;
      if (busReady) begin
        lat = n; drv = selDriven;
        break;
      end
    end
    busReq = 1'b0;
    check({tag, " R2/R3/R7/R9 select lines"}, 32'(csOk), 32'(1));
    check({tag, " R4/R8 cycles to ready"}, 32'(lat), 32'(w + 1));
    check({tag, " R3/R8 selDriven"}, 32'(drv), 32'(s != 4'b0));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset values
    check("R1 csN idle", 32'(csN), 32'hF);
    check("R1 ready low", 32'(busReady), 32'(0));
    readBack("R1");

    procMode = 2'b01;
    access("R2 cs0 top", 20'hFFFFF);
    access("R3 cs1 disabled", 20'hC0000);
    access("R2 below windows", 20'h7FFFF);

    regWrite(1'b0, 8'h0F);
    access("R2 cs3 low edge", 20'h80000);
    access("R2 cs2 high edge", 20'hBFFFF);
    regWrite(1'b1, 8'hFF);
    readBack("R5 all reserved");
    regWrite(1'b1, 8'hE4);
    readBack("R5 mixed fields");
    access("R4 cs2 code10", 20'hA1234);
    access("R4 cs1 code01", 20'hC8000);
    regWrite(1'b0, 8'h2F);
    readBack("R6 clear field1");
    access("R4 cs1 no wait", 20'hD0000);
    regWrite(1'b1, 8'h04);
    readBack("R5 nonzero under no-wait");

    procMode = 2'b00;
    access("R7 single-chip", 20'hF0000);
    procMode = 2'b11;
    access("R7 reserved mode", 20'hE0000);
    procMode = 2'b10;
    access("R7 micro mode", 20'hE0000);

    for (int it = 0; it < 400; it++) begin
      logic [19:0] a;
      if ($urandom % 2 == 0) regWrite(1'($urandom % 2), 8'($urandom));
      procMode = 2'($urandom);
      a = 20'($urandom);
      if ($urandom % 4 != 0) a[19] = 1'b1;
      readBack("rand");
      access("rand", a);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule